// File: doc/BRIEF.md
# Two-Strobe Command Framer

This block sits between an external host and on-chip command logic. The host sends each command as two active-low strobe pulses, and it presents one byte on a shared bus with each pulse. The block runs on its own free-running clock. It samples the strobe rather than clocking on it, ignores pulses that are too short to be real, and captures the byte when each valid pulse ends. It then decides whether that pulse opens or closes a command.

A plain alternating first/second toggle can end up permanently out of step after a power-up or a stray pulse. This block avoids that by using timing. The two pulses of one command always arrive close together, while commands are separated by long idle periods. If a second pulse does not arrive within a parameterised window after the first, the block abandons the half-built command and goes back to waiting for a first pulse. It also sets a sticky flag that records the event.

When a command completes, the block raises a one-cycle valid pulse. The two captured bytes are presented in the order they arrived, and they stay unchanged until the next command.

Top module: `strobe_pair_framer`

## Requirements
- R1: While reset is asserted, and after it is released, `cmd_valid`, `timeout_flag`, `cmd_first_byte` and `cmd_second_byte` are all 0, and the block waits for the first pulse of a command.
- R2: A pulse counts only if `strobe_n` is sampled low on at least MIN_LOW consecutive rising clock edges before it is sampled high again. A shorter low pulse has no effect on framing or on the outputs.
- R3: Each qualified pulse produces exactly one event, at its trailing (rising) edge. The byte for that pulse is the value of `data_in` at the first clock edge that samples `strobe_n` high again.
- R4: A qualified pulse that arrives while the block is waiting for a first pulse always opens a new command and stores its byte, whatever happened before.
- R5: Call the first clock edge that samples the second pulse's trailing edge high edge E. If the block was waiting for a second pulse at that point, `cmd_valid` rises right after edge E+3 and stays high for exactly one clock cycle.
- R6: When `cmd_valid` is high, `cmd_first_byte` holds the first pulse's byte and `cmd_second_byte` holds the second pulse's byte. Both stay unchanged at all other times.
- R7: Count the spacing between two pulses as the number of clock edges between their trailing-edge sample edges. If no second pulse comes within GAP_TIMEOUT edges of the first, the block drops the stored byte, produces no `cmd_valid`, and waits for a first pulse again.
- R8: `timeout_flag` rises right after edge E1+GAP_TIMEOUT+3, where E1 is the trailing-edge sample edge of the abandoned first pulse. Once set, it stays at 1 until reset.
- R9: A spacing of exactly GAP_TIMEOUT still completes the command, because the second pulse takes priority over expiry in the same cycle. A spacing of GAP_TIMEOUT+1 times out, and that late pulse opens a new command.
- R10: After a timeout caused by a stray pulse, the next properly timed pulse pair is framed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on a clock edge |
| strobe_n | input | 1 | Asynchronous active-low strobe from the host |
| data_in | input | DATA_W | Byte presented by the host with each strobe |
| cmd_valid | output | 1 | One-cycle pulse when a command completes |
| cmd_first_byte | output | DATA_W | Byte captured with the first pulse |
| cmd_second_byte | output | DATA_W | Byte captured with the second pulse |
| timeout_flag | output | 1 | Sticky: a first pulse was abandoned |

## Verification
Two things can happen in the same clock cycle: a second pulse's event arrives, and the gap counter reaches its expiry count. The bench sets up exactly this case by spacing two pulses precisely GAP_TIMEOUT edges apart. It then checks that the command completes and that the timeout flag stays clear. It also spaces a pair one edge wider and checks that expiry wins: the flag sets and the late pulse opens a new command. A behavioural model, which tracks pulse timing in edge counts, predicts `cmd_valid`, both bytes and the flag for every cycle.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic {
    ST_WANT_FIRST  = 1'b0,
    ST_WANT_SECOND = 1'b1
  } frame_state_e;
endpackage

// File: rtl/spf_sync.sv
// Two-stage synchronizer for an asynchronous input vector.
module spf_sync #(
  parameter int          W         = 1,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RESET_VAL;
      stage2_q <= RESET_VAL;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/spf_pulse_qual.sv
// Measures the low time of the synchronized strobe, and emits one event
// with the byte at the trailing edge of a pulse that was long enough.
module spf_pulse_qual #(
  parameter int MIN_LOW = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              evt,
  output logic [DATA_W-1:0] evt_byte
);
  localparam int              CW        = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0]   LOW_LIMIT = CW'(MIN_LOW);

  logic [CW-1:0]     low_cnt_q, low_cnt_d;
  logic              prev_q;
  logic              evt_q, evt_d;
  logic [DATA_W-1:0] byte_q;
  logic              rise;

  always_comb begin
    rise = strobe_s & ~prev_q;
    evt_d = rise && (low_cnt_q >= LOW_LIMIT);
    if (strobe_s)                    low_cnt_d = '0;
    else if (low_cnt_q == LOW_LIMIT) low_cnt_d = low_cnt_q;
    else                             low_cnt_d = low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      prev_q    <= 1'b1;
      evt_q     <= 1'b0;
      byte_q    <= '0;
    end else begin
      low_cnt_q <= low_cnt_d;
      prev_q    <= strobe_s;
      evt_q     <= evt_d;
      if (evt_d) byte_q <= data_s;
    end
  end

  assign evt      = evt_q;
  assign evt_byte = byte_q;

  // R3: one event per pulse, never on two adjacent cycles
  p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);
  // R2: an event follows a low-to-high transition of the synchronized strobe
  p_event_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> ($past(strobe_s) && !$past(strobe_s, 2)));
endmodule

// File: rtl/spf_frame_fsm.sv
// Pairs events into commands and abandons a half-built command on timeout.
module spf_frame_fsm
  import spf_pkg::*;
#(
  parameter int GAP_TIMEOUT = 64,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [DATA_W-1:0] evt_byte,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_first_byte,
  output logic [DATA_W-1:0] cmd_second_byte,
  output logic              timeout_flag
);
  localparam int            GW       = $clog2(GAP_TIMEOUT + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TIMEOUT - 1);

  frame_state_e      state_q, state_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              fire, expire;
  logic              valid_q;
  logic [DATA_W-1:0] out1_q, out2_q;
  logic              flag_q;

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    hold_d  = hold_q;
    fire    = 1'b0;
    expire  = 1'b0;
    unique case (state_q)
      ST_WANT_FIRST: begin
        if (evt) begin
          state_d = ST_WANT_SECOND;
          gap_d   = '0;
          hold_d  = evt_byte;
        end
      end
      ST_WANT_SECOND: begin
        if (evt) begin
          fire    = 1'b1;
          state_d = ST_WANT_FIRST;
          gap_d   = '0;
        end else if (gap_q == GAP_LAST) begin
          expire  = 1'b1;
          state_d = ST_WANT_FIRST;
          gap_d   = '0;
          hold_d  = '0;
        end else begin
          gap_d   = gap_q + 1'b1;
        end
      end
      default: state_d = ST_WANT_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WANT_FIRST;
      gap_q   <= '0;
      hold_q  <= '0;
      valid_q <= 1'b0;
      out1_q  <= '0;
      out2_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      hold_q  <= hold_d;
      valid_q <= fire;
      if (fire) begin
        out1_q <= hold_q;
        out2_q <= evt_byte;
      end
      if (expire) flag_q <= 1'b1;
    end
  end

  assign cmd_valid       = valid_q;
  assign cmd_first_byte  = out1_q;
  assign cmd_second_byte = out2_q;
  assign timeout_flag    = flag_q;

  // R5: the completion pulse lasts one cycle
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R6: the output bytes move only together with a completion pulse
  p_bytes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(out1_q) && $stable(out2_q)));
  // R8: the timeout flag never clears outside reset
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
  // R7: the gap counter never runs past the window
  p_gap_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WANT_SECOND) |-> (gap_q <= GAP_LAST));
  // R4: a completion only follows a pending first pulse
  p_valid_needs_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> ($past(state_q) == ST_WANT_SECOND));
endmodule

// File: rtl/strobe_pair_framer.sv
module strobe_pair_framer #(
  parameter int DATA_W      = 8,
  parameter int MIN_LOW     = 4,
  parameter int GAP_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic [DATA_W-1:0] data_in,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_first_byte,
  output logic [DATA_W-1:0] cmd_second_byte,
  output logic              timeout_flag
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              strobe_s;
  logic [DATA_W-1:0] data_s;
  logic              evt;
  logic [DATA_W-1:0] evt_byte;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  spf_sync #(.W(1), .RESET_VAL(1'b1)) u_sync_strobe (
    .clk(clk), .rst_n(rst_int_n), .d_async(strobe_n), .d_sync(strobe_s)
  );

  spf_sync #(.W(DATA_W), .RESET_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_int_n), .d_async(data_in), .d_sync(data_s)
  );

  spf_pulse_qual #(.MIN_LOW(MIN_LOW), .DATA_W(DATA_W)) u_qual (
    .clk(clk), .rst_n(rst_int_n), .strobe_s(strobe_s), .data_s(data_s),
    .evt(evt), .evt_byte(evt_byte)
  );

  spf_frame_fsm #(.GAP_TIMEOUT(GAP_TIMEOUT), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .evt(evt), .evt_byte(evt_byte),
    .cmd_valid(cmd_valid), .cmd_first_byte(cmd_first_byte),
    .cmd_second_byte(cmd_second_byte), .timeout_flag(timeout_flag)
  );

  // R1: nothing is reported while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!cmd_valid && !timeout_flag));
endmodule

// File: tb/tb_strobe_pair_framer.sv
module tb_strobe_pair_framer;
  localparam int DATA_W    = 8;
  localparam int MIN_LOW   = 4;
  localparam int GAP       = 64;
  localparam int MAX_INTRA = 20;
  localparam int NEVER     = 32'h7fffffff;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strobe_n = 1'b1;
  logic [DATA_W-1:0] data_in = '0;
  logic              cmd_valid;
  logic [DATA_W-1:0] cmd_first_byte, cmd_second_byte;
  logic              timeout_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  strobe_pair_framer #(.DATA_W(DATA_W), .MIN_LOW(MIN_LOW), .GAP_TIMEOUT(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .data_in(data_in),
    .cmd_valid(cmd_valid), .cmd_first_byte(cmd_first_byte),
    .cmd_second_byte(cmd_second_byte), .timeout_flag(timeout_flag)
  );

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, counted in clock edges
  int edge_no = 0;
  int low_run = 0;
  bit m_second = 0;
  int m_first_idx = 0;
  logic [DATA_W-1:0] m_first_byte = '0;
  int valid_at = -1;
  logic [DATA_W-1:0] pend1 = '0, pend2 = '0;
  int sticky_at = NEVER;
  bit exp_valid = 0;
  logic [DATA_W-1:0] exp_b1 = '0, exp_b2 = '0;
  bit exp_flag = 0;
  bit model_live = 0;
  int valid_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      low_run = 0; m_second = 0; valid_at = -1; sticky_at = NEVER;
      exp_valid = 0; exp_b1 = '0; exp_b2 = '0; exp_flag = 0; model_live = 0;
    end else begin
      edge_no++;
      model_live = 1;
      if (!strobe_n) low_run++;
      else begin
        if (low_run >= MIN_LOW) begin
          if (m_second && (edge_no - m_first_idx) <= GAP) begin
            valid_at = edge_no + 3; pend1 = m_first_byte; pend2 = data_in;
            m_second = 0;
          end else begin
            if (m_second && (m_first_idx + GAP + 3) < sticky_at) sticky_at = m_first_idx + GAP + 3;
            m_second = 1; m_first_idx = edge_no; m_first_byte = data_in;
          end
        end
        low_run = 0;
      end
      if (m_second && edge_no == m_first_idx + GAP + 3 && edge_no < sticky_at) sticky_at = edge_no;
      exp_valid = (edge_no == valid_at);
      if (exp_valid) begin exp_b1 = pend1; exp_b2 = pend2; end
      exp_flag = (edge_no >= sticky_at);
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_live && !done) begin
      chk("R5 cmd_valid timing", cmd_valid, exp_valid);
      chk("R6 first byte", cmd_first_byte, exp_b1);
      chk("R6 second byte", cmd_second_byte, exp_b2);
      chk("R8 timeout flag", timeout_flag, exp_flag);
      if (cmd_valid) valid_seen++;
    end
  end

  task automatic pulse(input int len, input logic [DATA_W-1:0] b);
    strobe_n = 1'b0; data_in = b;
    repeat (len) @(negedge clk);
    strobe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (2) @(negedge clk);
    data_in = ~data_in;
    repeat (n - 2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", cmd_valid, 0);
    chk("R1 reset flag", timeout_flag, 0);
    chk("R1 reset first byte", cmd_first_byte, 0);
    chk("R1 reset second byte", cmd_second_byte, 0);
    rst_n = 1'b1;
    idle(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    @(negedge clk);
    do_reset();
    chk("R9 window exceeds intra spacing", GAP > MAX_INTRA, 1);

    // R4 R5 R6: plain command
    base = valid_seen;
    pulse(5, 8'hA5); idle(10); pulse(5, 8'h3C); idle(20);
    chk("R5 one command", valid_seen - base, 1);
    chk("R6 first byte A5", cmd_first_byte, 8'hA5);
    chk("R6 second byte 3C", cmd_second_byte, 8'h3C);

    // R2: short glitch ahead of and inside a command
    base = valid_seen;
    pulse(MIN_LOW - 1, 8'h11); idle(8);
    pulse(MIN_LOW, 8'h22); idle(5); pulse(6, 8'h33); idle(GAP + 10);
    pulse(4, 8'h44); idle(5); pulse(MIN_LOW - 1, 8'h99); idle(5); pulse(4, 8'h55); idle(20);
    chk("R2 glitches ignored", valid_seen - base, 2);
    chk("R2 byte 44", cmd_first_byte, 8'h44);
    chk("R2 byte 55", cmd_second_byte, 8'h55);
    chk("R2 no timeout", timeout_flag, 0);

    // R9: spacing exactly GAP completes
    base = valid_seen;
    idle(GAP);
    pulse(4, 8'hA1); idle(GAP - 4); pulse(4, 8'hB2); idle(GAP + 10);
    chk("R9 exact window accepted", valid_seen - base, 1);
    chk("R9 byte B2", cmd_second_byte, 8'hB2);
    chk("R9 no timeout at boundary", timeout_flag, 0);

    // R7 R8 R10: stray pulse, timeout, then recovery
    base = valid_seen;
    pulse(4, 8'h66); idle(GAP + 20);
    chk("R7 no command from lone pulse", valid_seen - base, 0);
    chk("R8 flag raised", timeout_flag, 1);
    pulse(4, 8'h77); idle(8); pulse(4, 8'h88); idle(20);
    chk("R10 resynced command", valid_seen - base, 1);
    chk("R10 byte 77", cmd_first_byte, 8'h77);
    chk("R10 byte 88", cmd_second_byte, 8'h88);

    // R9: spacing GAP+1 expires; late pulse opens a new command
    base = valid_seen;
    idle(GAP);
    pulse(4, 8'hC3); idle(GAP - 3); pulse(4, 8'hD4); idle(10); pulse(4, 8'hE5); idle(20);
    chk("R9 late pulse starts new command", valid_seen - base, 1);
    chk("R9 byte D4", cmd_first_byte, 8'hD4);
    chk("R9 byte E5", cmd_second_byte, 8'hE5);
    chk("R8 flag still set", timeout_flag, 1);

    // R8 R1: only reset clears the flag
    do_reset();
    chk("R8 flag cleared by reset", timeout_flag, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule